// File: doc/BRIEF.md
# Single-Setting Two-Wire Slave

This block is a two-wire serial slave that owns one 8-bit setting register. The register's upper five bits set a converter code and the lower three bits drive three logic outputs. A bus master writes the setting with a two-byte transfer (address byte, then the data byte) and reads it back the same way. No register pointer exists: the byte after the address is always the setting itself.

The bus lines are sampled by the system clock through a synchroniser. START and STOP are decoded from the synchronised levels, and the block acknowledges only its own 7-bit address. SDA is driven as an open-drain line: the block only ever pulls it low, through a drive-enable output. The converter level presented on the output is the bitwise complement of the stored code, so a code of all ones gives the lowest level.

Top module: `trimSlave`

## Requirements
- R1: After reset the setting register holds 00h, so `dacLevel` is 31, `pinOut` is 0 and `sdaDrvEn` is 0.
- R2: A transfer of START, address byte 58h (7-bit address 2Ch, bit 0 = 0 for write), data byte, STOP loads the data byte into the setting register.
- R3: When the 7-bit address in bits 7:1 of the first byte after START equals 2Ch, the block pulls SDA low during the ninth clock of that byte.
- R4: When the address does not match, the block never pulls SDA low and ignores all traffic until the next START; the setting register keeps its value.
- R5: After address byte 59h (bit 0 = 1, read), the block drives the setting register onto SDA most significant bit first, changing SDA only after SCL has fallen.
- R6: After the eighth read data bit the block releases SDA so the master's acknowledge bit is seen on the bus.
- R7: The block pulls SDA low during the ninth clock after a write data byte, and the register changes only while that acknowledge is driven.
- R8: A STOP in the middle of the data byte aborts the transfer and leaves the setting register unchanged.
- R9: A START in the middle of a byte aborts the transfer and begins a new address phase that is then served normally.
- R10: `dacLevel` equals the bitwise complement of register bits 7:3, and `pinOut[2:0]` equals register bits 2:0 (1 = high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level as seen on the bus |
| sdaDrvEn | output | 1 | 1 pulls SDA low; 0 releases it |
| dacLevel | output | 5 | Converter drive level, complement of register bits 7:3 |
| pinOut | output | 3 | Logic outputs taken from register bits 2:0 |

## Verification
The assertions take for granted a master that keeps to the bus rules: SDA moves only while SCL is low, except for START and STOP, and each SCL level lasts several system clocks longer than the synchroniser delay. Under those conditions the drive enable can only change while the synchronised clock is low, and the master never tries to signal STOP over an acknowledge the slave is holding. The stimulus keeps every SCL phase eight clocks long and changes SDA a quarter bit after the falling edge, and both aborted transfers are placed while the slave has SDA released.

// File: rtl/trimPkg.sv
`timescale 1ns/1ps
package trimPkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_END,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WDATA_END,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_IGNORE
  } busState_t;

  // Strobes from control to datapath, at most one per cycle.
  typedef struct packed {
    logic shiftIn;
    logic loadRead;
    logic shiftOut;
    logic commit;
  } dpCmd_t;

endpackage

// File: rtl/trimCtrl.sv
`timescale 1ns/1ps
module trimCtrl
  import trimPkg::*;
#(
  parameter int REG_W  = 8,
  parameter int SYNC_N = 2,
  parameter logic [REG_W-2:0] DEV_ADDR = 7'h2C
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [REG_W-1:0] rxByte,
  input  logic             txBit,
  output dpCmd_t           cmd,
  output logic             sdaBit,
  output logic             sdaDrvEn
);

  localparam int CNT_W = $clog2(REG_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(REG_W - 1);

  logic [SYNC_N-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclQ, sdaQ;
  logic sclRise, sclFall, startDet, stopDet;

  busState_t state, stateNx;
  logic [CNT_W-1:0] cnt, cntNx;
  logic rw, rwNx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_N-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_N-2:0], sdaIn};
      sclQ    <= sclS;
      sdaQ    <= sdaS;
    end
  end

  assign sclS     = sclPipe[SYNC_N-1];
  assign sdaS     = sdaPipe[SYNC_N-1];
  assign sdaBit   = sdaS;
  assign sclRise  = sclS & ~sclQ;
  assign sclFall  = ~sclS & sclQ;
  assign startDet = sclS & sclQ & sdaQ & ~sdaS;
  assign stopDet  = sclS & sclQ & ~sdaQ & sdaS;

  always_comb begin
    stateNx = state;
    cntNx   = cnt;
    rwNx    = rw;
    cmd     = '0;
    if (startDet) begin
      stateNx = ST_ADDR;
      cntNx   = '0;
    end else if (stopDet) begin
      stateNx = ST_IDLE;
    end else begin
      case (state)
        ST_ADDR, ST_WDATA: begin
          if (sclRise) begin
            cmd.shiftIn = 1'b1;
            if (cnt == LAST_BIT) begin
              stateNx = (state == ST_ADDR) ? ST_ADDR_END : ST_WDATA_END;
              cntNx   = '0;
            end else begin
              cntNx = cnt + CNT_W'(1);
            end
          end
        end
        ST_ADDR_END: begin
          if (sclFall) begin
            if (rxByte[REG_W-1:1] == DEV_ADDR) begin
              stateNx = ST_ADDR_ACK;
              rwNx    = rxByte[0];
            end else begin
              stateNx = ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            cntNx = '0;
            if (rw) begin
              stateNx      = ST_RDATA;
              cmd.loadRead = 1'b1;
            end else begin
              stateNx = ST_WDATA;
            end
          end
        end
        ST_WDATA_END: begin
          if (sclFall) begin
            stateNx    = ST_WDATA_ACK;
            cmd.commit = 1'b1;
          end
        end
        ST_WDATA_ACK: begin
          if (sclFall) stateNx = ST_IGNORE;
        end
        ST_RDATA: begin
          if (sclFall) begin
            if (cnt == LAST_BIT) begin
              stateNx = ST_IGNORE;
            end else begin
              cmd.shiftOut = 1'b1;
              cntNx        = cnt + CNT_W'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      rw    <= 1'b0;
    end else begin
      state <= stateNx;
      cnt   <= cntNx;
      rw    <= rwNx;
    end
  end

  assign sdaDrvEn = (state == ST_ADDR_ACK) || (state == ST_WDATA_ACK) ||
                    ((state == ST_RDATA) && !txBit);

  // R6 / R5: the slave only moves SDA while the clock is low
  p_drive_scl_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDrvEn) |-> !sclS);

  // R9: any START restarts the address phase from bit zero
  p_start_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_ADDR && cnt == '0));

  // R2: datapath strobes never collide
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmd));

endmodule

// File: rtl/trimData.sv
`timescale 1ns/1ps
module trimData
  import trimPkg::*;
#(
  parameter int DAC_W = 5,
  parameter int PIN_W = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCmd_t                 cmd,
  input  logic                   sdaBit,
  output logic [DAC_W+PIN_W-1:0] rxByte,
  output logic                   txBit,
  output logic [DAC_W+PIN_W-1:0] regVal,
  output logic [DAC_W-1:0]       dacLevel,
  output logic [PIN_W-1:0]       pinOut
);

  localparam int REG_W = DAC_W + PIN_W;

  logic [REG_W-1:0] shReg, setReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (cmd.shiftIn) begin
      shReg <= {shReg[REG_W-2:0], sdaBit};
    end else if (cmd.loadRead) begin
      shReg <= setReg;
    end else if (cmd.shiftOut) begin
      shReg <= {shReg[REG_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           setReg <= '0;
    else if (cmd.commit) setReg <= shReg;
  end

  assign rxByte   = shReg;
  assign txBit    = shReg[REG_W-1];
  assign regVal   = setReg;
  assign dacLevel = ~setReg[REG_W-1 -: DAC_W];

  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    assign pinOut[i] = setReg[i];
  end

endmodule

// File: rtl/trimSlave.sv
`timescale 1ns/1ps
module trimSlave
  import trimPkg::*;
#(
  parameter int DAC_W  = 5,
  parameter int PIN_W  = 3,
  parameter int SYNC_N = 2,
  parameter logic [DAC_W+PIN_W-2:0] DEV_ADDR = 7'h2C
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaDrvEn,
  output logic [DAC_W-1:0] dacLevel,
  output logic [PIN_W-1:0] pinOut
);

  localparam int REG_W = DAC_W + PIN_W;

  dpCmd_t cmd;
  logic sdaBit, txBit;
  logic [REG_W-1:0] rxByte, regVal;

  trimCtrl #(
    .REG_W(REG_W), .SYNC_N(SYNC_N), .DEV_ADDR(DEV_ADDR)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .txBit(txBit), .cmd(cmd),
    .sdaBit(sdaBit), .sdaDrvEn(sdaDrvEn)
  );

  trimData #(
    .DAC_W(DAC_W), .PIN_W(PIN_W)
  ) uData (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sdaBit(sdaBit),
    .rxByte(rxByte), .txBit(txBit), .regVal(regVal),
    .dacLevel(dacLevel), .pinOut(pinOut)
  );

  // R7 / R8: the setting only changes while the data acknowledge is held
  p_reg_update_acked_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regVal) |-> sdaDrvEn);

  // R5: the first read bit presented is the register MSB
  p_read_msb_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.loadRead |=> (sdaDrvEn == !regVal[REG_W-1]));

endmodule

// File: tb/trimSlave_test.sv
`timescale 1ns/1ps
module trimSlave_test;

  localparam int Q = 4;
  localparam int NVEC = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic busSda;
  logic sdaDrvEn;
  logic [4:0] dacLevel;
  logic [2:0] pinOut;
  int checks = 0;
  int fails = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  assign busSda = mSda & ~sdaDrvEn;

  trimSlave uut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(busSda),
    .sdaDrvEn(sdaDrvEn), .dacLevel(dacLevel), .pinOut(pinOut)
  );

  // {address byte, data byte, expected ack, expected register afterwards}
  localparam logic [24:0] VEC [0:NVEC-1] = '{
    {8'h58, 8'hA5, 1'b1, 8'hA5},
    {8'h58, 8'h00, 1'b1, 8'h00},
    {8'h58, 8'hFF, 1'b1, 8'hFF},
    {8'h5A, 8'h12, 1'b0, 8'hFF},
    {8'h58, 8'h3C, 1'b1, 8'h3C},
    {8'hB0, 8'h77, 1'b0, 8'h3C},
    {8'h58, 8'hF8, 1'b1, 8'hF8}
  };

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clockBit(input logic drive, output logic seen);
    waitQ(); mSda = drive;
    waitQ(); mScl = 1'b1;
    waitQ(); seen = busSda;
    waitQ(); mScl = 1'b0;
  endtask

  task automatic startCond();
    waitQ(); mSda = 1'b1;
    waitQ(); mScl = 1'b1;
    waitQ(); mSda = 1'b0;
    waitQ(); mScl = 1'b0;
  endtask

  task automatic stopCond();
    waitQ(); mSda = 1'b0;
    waitQ(); mScl = 1'b1;
    waitQ(); mSda = 1'b1;
    waitQ();
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ackd);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, s);
    ackd = !s;
  endtask

  task automatic readByte(output logic [7:0] v, output logic relSeen);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      v[i] = s;
    end
    clockBit(1'b1, relSeen);  // master NACK; bus must stay high
  endtask

  task automatic checkOutputs(input string req, input logic [7:0] exp);
    chk(req, {3'b000, dacLevel}, {3'b000, ~exp[7:3]});
    chk(req, {5'b00000, pinOut}, {5'b00000, exp[2:0]});
  endtask

  task automatic readBack(input string req, input logic [7:0] exp);
    logic a, rel;
    logic [7:0] v;
    startCond();
    writeByte(8'h59, a);
    chk("R3 read address ack", {7'd0, a}, 8'd1);
    readByte(v, rel);
    chk(req, v, exp);
    chk("R6 release after read byte", {7'd0, rel}, 8'd1);
    stopCond();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic a1, a2;
    logic [7:0] expReg;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    chk("R1 reset sdaDrvEn", {7'd0, sdaDrvEn}, 8'd0);
    checkOutputs("R1 reset outputs", 8'h00);
    readBack("R1 reset readback", 8'h00);

    // Table walk: R2 R3 R4 R5 R7 R10
    for (int k = 0; k < NVEC; k++) begin
      expReg = VEC[k][7:0];
      startCond();
      writeByte(VEC[k][24:17], a1);
      chk("R3/R4 address ack", {7'd0, a1}, {7'd0, VEC[k][8]});
      writeByte(VEC[k][16:9], a2);
      chk("R7/R4 data ack", {7'd0, a2}, {7'd0, VEC[k][8]});
      stopCond();
      repeat (4) @(negedge clk);
      checkOutputs("R2/R10 outputs", expReg);
      readBack("R5 readback", expReg);
    end

    // R8: STOP after four data bits leaves register at F8
    begin
      logic s;
      startCond();
      writeByte(8'h58, a1);
      chk("R8 address ack", {7'd0, a1}, 8'd1);
      for (int i = 0; i < 4; i++) clockBit(1'b0, s);
      stopCond();
      repeat (4) @(negedge clk);
      checkOutputs("R8 stop mid-byte", 8'hF8);
      readBack("R8 readback", 8'hF8);
    end

    // R9: repeated START mid data byte, then a full new write
    begin
      logic s;
      startCond();
      writeByte(8'h58, a1);
      for (int i = 0; i < 5; i++) clockBit(1'b1, s);
      startCond();
      writeByte(8'h58, a1);
      chk("R9 restart address ack", {7'd0, a1}, 8'd1);
      writeByte(8'h81, a2);
      chk("R9 restart data ack", {7'd0, a2}, 8'd1);
      stopCond();
      repeat (4) @(negedge clk);
      checkOutputs("R9 outputs", 8'h81);
    end

    // R9: repeated START in the middle of the address byte
    begin
      logic s;
      startCond();
      for (int i = 0; i < 3; i++) clockBit(1'b0, s);
      startCond();
      writeByte(8'h58, a1);
      chk("R9 restart in address", {7'd0, a1}, 8'd1);
      writeByte(8'h06, a2);
      stopCond();
      repeat (4) @(negedge clk);
      checkOutputs("R9 second outputs", 8'h06);
    end

    // R4: traffic after a mismatch is ignored even if it looks like a match
    startCond();
    writeByte(8'h5E, a1);
    writeByte(8'h58, a2);
    chk("R4 ignored second byte", {7'd0, a2}, 8'd0);
    writeByte(8'hC3, a2);
    chk("R4 ignored third byte", {7'd0, a2}, 8'd0);
    stopCond();
    repeat (4) @(negedge clk);
    checkOutputs("R4 register kept", 8'h06);

    // R1: reset in mid-operation returns the setting to 00h
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkOutputs("R1 reset again", 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule